// File: doc/BRIEF.md
# UART FIFO Interrupt Controller

This block is the buffering and interrupt layer between a UART's register interface and its serial core. Bytes written from the bus wait in a transmit FIFO until the transmitter pops them. Characters from the receiver wait in a receive FIFO until the bus reads them. Each receive entry carries per-character error flags next to its data byte. Both FIFOs are 32 entries deep. A single control input cuts each of them down to a one-entry holding register.

Five interrupt sources feed one request line:
- transmit level
- receive level
- receive timeout
- modem status change
- character error

Each source has a raw status bit and its own mask bit. The two level sources track the FIFO fill against a threshold that is set as a fraction of the current depth. They clear by themselves. The modem and error sources latch until software writes a one to their clear bit. The serial core reaches the block only through pop and push strobes, a bit-period tick and a modem-change pulse.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset both FIFOs are empty, `raw_stat` equals 5'b00001 (only the transmit level source is active) and `irq` is low.
- R2: The transmit FIFO stores up to DEPTH (32) bytes. It returns them on `tx_rdata` in write order, and `tx_level` reports the number held.
- R3: A transmit write while `tx_full` is high is discarded. A transmit pop while empty has no effect, and a later write is still read back correctly.
- R4: A receive entry is 12 bits: [7:0] data, [8] framing error, [9] parity error, [10] break, [11] overrun. On push, `rx_flags[0]`, `rx_flags[1]` and `rx_flags[2]` supply bits 8, 9 and 10. Entries are read back in arrival order.
- R5: A push into a full receive FIFO is not stored. Instead it sets bit 11 of the most recently stored entry and sets the error status bit.
- R6: With `fifo_en` low, each FIFO holds one entry. Any change of `fifo_en` empties both FIFOs on the following clock edge.
- R7: The select codes 0 through 4 pick 1/8, 1/4, 1/2, 3/4 and 7/8 of the current depth. Codes 5 to 7 pick 1/2. The threshold is floor(depth × eighths / 8).
- R8: `raw_stat[0]` (transmit) is high whenever the transmit level is at or below its threshold.
- R9: `raw_stat[1]` (receive) is high whenever the receive FIFO is not empty and its level is at or above its threshold.
- R10: `raw_stat[2]` (timeout) rises once the receive FIFO has stayed non-empty for 32 `bit_tick` pulses with no push or read. A push, a read or an empty FIFO clears it.
- R11: `raw_stat[3]` latches on `modem_chg`. `raw_stat[4]` latches on a pushed character with any flag set, or on an overrun. Each clears when `clr_wr` is pulsed with its bit in `clr_bits` set. A new set in the same cycle wins over the clear.
- R12: `mask_stat` is `raw_stat` AND `irq_mask`, and `irq` is high exactly when some bit of `mask_stat` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: full-depth FIFOs, 0: one-entry holding registers |
| tx_sel | input | 3 | Transmit threshold fraction select |
| rx_sel | input | 3 | Receive threshold fraction select |
| irq_mask | input | 5 | Per-source enable {err, modem, timeout, rx, tx} |
| clr_wr | input | 1 | Write strobe for the clear register |
| clr_bits | input | 5 | Write-one-to-clear bits, same layout as `raw_stat` |
| tx_wr | input | 1 | Bus write into the transmit FIFO |
| tx_wdata | input | 8 | Byte to write |
| tx_pop | input | 1 | Transmitter takes the head byte |
| tx_rdata | output | 8 | Head byte of the transmit FIFO |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| tx_level | output | 6 | Transmit entries held |
| rx_push | input | 1 | Receiver delivers a character |
| rx_data | input | 8 | Received byte |
| rx_flags | input | 3 | {break, parity, framing} for the character |
| rx_rd | input | 1 | Bus reads the head entry |
| rx_rdata | output | 12 | Head entry of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_level | output | 6 | Receive entries held |
| bit_tick | input | 1 | One pulse per serial bit period |
| modem_chg | input | 1 | Modem line change pulse |
| raw_stat | output | 5 | Raw status {err, modem, timeout, rx, tx} |
| mask_stat | output | 5 | Masked status |
| irq | output | 1 | Combined interrupt request |

## Verification
The bound checker evaluates cycle-level rules on every clock:
- a write into a full transmit FIFO leaves its level unchanged;
- a pop from an empty transmit FIFO leaves it empty;
- a receive overrun and a modem change both show up in the latched status one cycle later;
- the timeout bit is never high while the receive FIFO is empty.

Some behaviour can only be shown by the bench scenarios:
- data and flag ordering through both FIFOs;
- the exact thresholds of each fraction code;
- the 32-tick timeout boundary;
- the overrun mark on the newest entry;
- the flush and single-entry behaviour when `fifo_en` changes.

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int TMO   = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1,
  localparam int RW = DW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [2:0]    tx_sel,
  input  logic [2:0]    rx_sel,
  input  logic [4:0]    irq_mask,
  input  logic          clr_wr,
  input  logic [4:0]    clr_bits,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  output logic          tx_empty,
  output logic          tx_full,
  output logic [LW-1:0] tx_level,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  input  logic [2:0]    rx_flags,
  input  logic          rx_rd,
  output logic [RW-1:0] rx_rdata,
  output logic          rx_empty,
  output logic          rx_full,
  output logic [LW-1:0] rx_level,
  input  logic          bit_tick,
  input  logic          modem_chg,
  output logic [4:0]    raw_stat,
  output logic [4:0]    mask_stat,
  output logic          irq
);
  localparam int TW = $clog2(TMO + 1);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [RW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_cnt, rx_cnt;
  logic [TW-1:0] idle;
  logic          fe_q, st_mod, st_err;

  function automatic logic [LW-1:0] thr(input logic [2:0] sel, input logic [LW-1:0] c);
    int e;
    case (sel)
      3'd0: e = 1;
      3'd1: e = 2;
      3'd3: e = 6;
      3'd4: e = 7;
      default: e = 4;
    endcase
    return LW'((int'(c) * e) >> 3);
  endfunction

  wire [LW-1:0] cap   = fifo_en ? LW'(DEPTH) : LW'(1);
  wire          flush = fifo_en != fe_q;
  wire          tx_wok = tx_wr && !tx_full;
  wire          tx_pok = tx_pop && !tx_empty;
  wire          rx_wok = rx_push && !rx_full;
  wire          rx_ovr = rx_push && rx_full;
  wire          rx_pok = rx_rd && !rx_empty;

  assign tx_empty = tx_cnt == '0;
  assign tx_full  = tx_cnt >= cap;
  assign tx_level = tx_cnt;
  assign tx_rdata = tx_mem[tx_rp];
  assign rx_empty = rx_cnt == '0;
  assign rx_full  = rx_cnt >= cap;
  assign rx_level = rx_cnt;
  assign rx_rdata = rx_mem[rx_rp];

  always_ff @(posedge clk) begin
    if (tx_wok) tx_mem[tx_wp] <= tx_wdata;
    if (rx_wok) rx_mem[rx_wp] <= {1'b0, rx_flags, rx_data};
    else if (rx_ovr) rx_mem[rx_wp - AW'(1)][RW-1] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_q <= 1'b1;
      {tx_wp, tx_rp, tx_cnt} <= '0;
      {rx_wp, rx_rp, rx_cnt} <= '0;
    end else begin
      fe_q <= fifo_en;
      if (flush) begin
        {tx_wp, tx_rp, tx_cnt} <= '0;
        {rx_wp, rx_rp, rx_cnt} <= '0;
      end else begin
        if (tx_wok) tx_wp <= tx_wp + AW'(1);
        if (tx_pok) tx_rp <= tx_rp + AW'(1);
        tx_cnt <= tx_cnt + LW'(tx_wok) - LW'(tx_pok);
        if (rx_wok) rx_wp <= rx_wp + AW'(1);
        if (rx_pok) rx_rp <= rx_rp + AW'(1);
        rx_cnt <= rx_cnt + LW'(rx_wok) - LW'(rx_pok);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle   <= '0;
      st_mod <= 1'b0;
      st_err <= 1'b0;
    end else begin
      if (flush || rx_push || rx_rd || rx_empty) idle <= '0;
      else if (bit_tick && idle != TW'(TMO)) idle <= idle + TW'(1);
      st_mod <= (st_mod && !(clr_wr && clr_bits[3])) || modem_chg;
      st_err <= (st_err && !(clr_wr && clr_bits[4])) || (rx_wok && |rx_flags) || rx_ovr;
    end
  end

  assign raw_stat[0] = tx_cnt <= thr(tx_sel, cap);
  assign raw_stat[1] = !rx_empty && rx_cnt >= thr(rx_sel, cap);
  assign raw_stat[2] = !rx_empty && idle == TW'(TMO);
  assign raw_stat[3] = st_mod;
  assign raw_stat[4] = st_err;
  assign mask_stat   = raw_stat & irq_mask;
  assign irq         = |mask_stat;
endmodule

module uart_fifo_irq_chk #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          tx_wr,
  input logic          tx_pop,
  input logic          tx_full,
  input logic          tx_empty,
  input logic [LW-1:0] tx_level,
  input logic          rx_push,
  input logic          rx_full,
  input logic          rx_empty,
  input logic          modem_chg,
  input logic [4:0]    raw_stat
);
  // R3
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && tx_wr && !tx_pop && $stable(fifo_en) |=> $stable(tx_level));
  // R3
  tx_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty && tx_pop && !tx_wr && $stable(fifo_en) |=> tx_empty);
  // R5
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && rx_push |=> raw_stat[4]);
  // R11
  modem_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modem_chg |=> raw_stat[3]);
  // R10
  timeout_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_stat[2] |-> !rx_empty);
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_wr(tx_wr), .tx_pop(tx_pop),
  .tx_full(tx_full), .tx_empty(tx_empty), .tx_level(tx_level), .rx_push(rx_push),
  .rx_full(rx_full), .rx_empty(rx_empty), .modem_chg(modem_chg), .raw_stat(raw_stat)
);

// File: tb/test_uart_fifo_irq.sv
module test_uart_fifo_irq;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 1, clr_wr = 0, tx_wr = 0, tx_pop = 0, rx_push = 0, rx_rd = 0;
  logic bit_tick = 0, modem_chg = 0;
  logic [2:0] tx_sel = 0, rx_sel = 0, rx_flags = 0;
  logic [4:0] irq_mask = 0, clr_bits = 0;
  logic [7:0] tx_wdata = 0, rx_data = 0;
  logic [7:0] tx_rdata;
  logic [11:0] rx_rdata;
  logic tx_empty, tx_full, rx_empty, rx_full, irq;
  logic [5:0] tx_level, rx_level;
  logic [4:0] raw_stat, mask_stat;

  int checks = 0, fails = 0, cap = 32;
  bit done = 0;
  logic [7:0]  txq[$];
  logic [11:0] rxq[$];

  uart_fifo_irq i_uart_fifo_irq (.*);

  always #10 clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    tx_wr = 0; tx_pop = 0; rx_push = 0; rx_rd = 0;
    clr_wr = 0; bit_tick = 0; modem_chg = 0;
  endtask

  task automatic tx_put(input logic [7:0] b);
    tx_wr = 1; tx_wdata = b;
    if (txq.size() < cap) txq.push_back(b);
    tick();
  endtask

  task automatic tx_take(input string r);
    chk(r, tx_rdata, txq.pop_front());
    tx_pop = 1; tick();
  endtask

  task automatic rx_put(input logic [7:0] d, input logic [2:0] f);
    rx_push = 1; rx_data = d; rx_flags = f;
    if (rxq.size() < cap) rxq.push_back({1'b0, f, d});
    else rxq[rxq.size()-1][11] = 1'b1;
    tick();
  endtask

  task automatic rx_take(input string r);
    chk(r, rx_rdata, rxq.pop_front());
    rx_rd = 1; tick();
  endtask

  task automatic clear(input logic [4:0] b);
    clr_wr = 1; clr_bits = b; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #45; rst_n = 1; tick();
    // R1 reset state
    chk("R1 tx_empty", tx_empty, 1); chk("R1 rx_empty", rx_empty, 1);
    chk("R1 raw", raw_stat, 5'b00001); chk("R1 irq", irq, 0);

    // R2 ordering
    for (int i = 0; i < 5; i++) tx_put(8'hA0 + 8'(i));
    chk("R2 level", tx_level, 5);
    while (txq.size() > 0) tx_take("R2 data");
    chk("R2 empty", tx_empty, 1);

    // R8 transmit threshold at 1/8 -> 4
    tx_sel = 0;
    for (int i = 0; i < 4; i++) tx_put(8'(i));
    chk("R8 at 4", raw_stat[0], 1);
    tx_put(8'h44);
    chk("R8 at 5", raw_stat[0], 0);
    while (txq.size() > 0) tx_take("R8 data");

    // R3 overflow and underflow
    for (int i = 0; i < 33; i++) tx_put(8'(i * 3));
    chk("R3 full", tx_full, 1); chk("R3 level", tx_level, 32);
    while (txq.size() > 0) tx_take("R3 data");
    tx_pop = 1; tick();
    chk("R3 empty pop", tx_level, 0);
    tx_put(8'h5A);
    tx_take("R3 after underflow");

    // R4/R9 receive at 1/4 -> 8, R11 error latch
    rx_sel = 1;
    for (int i = 0; i < 7; i++) rx_put(8'h10 + 8'(i), 3'(i));
    chk("R9 at 7", raw_stat[1], 0);
    rx_put(8'h17, 3'b100);
    chk("R9 at 8", raw_stat[1], 1);
    chk("R11 err set", raw_stat[4], 1);
    clear(5'b10000);
    chk("R11 err clr", raw_stat[4], 0);
    while (rxq.size() > 0) rx_take("R4 entry");
    chk("R9 empty", raw_stat[1], 0);

    // R7 code 5 -> 1/2 = 16, then R5 overrun
    rx_sel = 5;
    for (int i = 0; i < 15; i++) rx_put(8'(i), 3'b000);
    chk("R7 rx 15", raw_stat[1], 0);
    rx_put(8'h0F, 3'b000);
    chk("R7 rx 16", raw_stat[1], 1);
    for (int i = 16; i < 32; i++) rx_put(8'(i), 3'b000);
    chk("R5 no err yet", raw_stat[4], 0);
    rx_put(8'hEE, 3'b000);
    chk("R5 err", raw_stat[4], 1); chk("R5 level", rx_level, 32);
    while (rxq.size() > 0) rx_take("R5 entry");
    clear(5'b10000);

    // R7 code 4 -> 7/8 = 28 on transmit
    tx_sel = 4;
    for (int i = 0; i < 28; i++) tx_put(8'(i));
    chk("R7 tx 28", raw_stat[0], 1);
    tx_put(8'h77);
    chk("R7 tx 29", raw_stat[0], 0);
    while (txq.size() > 0) tx_take("R7 data");

    // R10 timeout
    rx_put(8'h3C, 3'b000);
    for (int i = 0; i < 31; i++) begin bit_tick = 1; tick(); tick(); end
    chk("R10 at 31", raw_stat[2], 0);
    bit_tick = 1; tick();
    chk("R10 at 32", raw_stat[2], 1);
    rx_take("R10 data");
    chk("R10 cleared", raw_stat[2], 0);

    // R11/R12 modem and masking
    modem_chg = 1; tick();
    chk("R11 modem", raw_stat[3], 1);
    irq_mask = 5'b01000; #1;
    chk("R12 mstat", mask_stat, 5'b01000); chk("R12 irq", irq, 1);
    irq_mask = 5'b00001; #1;
    chk("R12 tx mstat", mask_stat, 5'b00001);
    irq_mask = 5'b00000; #1;
    chk("R12 off", irq, 0);
    clear(5'b11000);
    chk("R11 modem clr", raw_stat[4:3], 2'b00);

    // R6 flush and single-entry mode
    for (int i = 0; i < 3; i++) tx_put(8'(i));
    fifo_en = 0; cap = 1; txq.delete(); tick();
    chk("R6 flushed", tx_level, 0);
    tx_put(8'hC1); tx_put(8'hC2);
    chk("R6 tx full", tx_full, 1); chk("R6 tx level", tx_level, 1);
    tx_take("R6 tx data");
    rx_put(8'hD1, 3'b001); rx_put(8'hD2, 3'b000);
    chk("R6 rx level", rx_level, 1);
    rx_take("R6 rx entry");
    finish_run();
  end
endmodule